// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a fully associative translation cache with a parameterized entry count (32 by default). Each entry holds a virtual tag, a physical base, a page-size code and a valid flag. A combinational lookup port turns a virtual address into a physical address by matching against every entry at once, each entry under its own page size.

All state changes come through one command port, one command per cycle, and take effect at the next rising clock edge. A lock boundary register marks the lowest-indexed entries as protected. Protected entries are never picked as victims for table-walk fills and a global flush leaves them alone. Software builds a locked region by loading pinned entries one at a time: each pinned load writes the slot at the boundary and moves the boundary up by one. The region can only be shrunk from the top, by writing a lower boundary value. A flush by virtual address removes every matching entry, locked or not.

Top module: `lock_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses with `lk_paddr` = 0, and `lock_base` is 0.
- R2: A lookup compares only the virtual-address bits above the entry's page offset. Size code 2 is a 4 KB page and compares [31:12]. Code 1 is a 64 KB page and compares [31:16]. Code 0 is a 1 MB page and compares [31:20]. Code 3 is a 16 MB page and compares [31:24]. On a hit, `lk_paddr` is the stored physical base in the compared bits and the lookup address in the offset bits. On a miss it is 0.
- R3: When several valid entries match, the lowest index wins, and `lk_index` reports that index.
- R4: A fill command (op 1) writes the entry at a round-robin victim pointer. The pointer cycles over the indices from `lock_base` to NUM_ENTRIES-1 and then wraps to `lock_base`. When the pointer lies below `lock_base`, the victim is `lock_base`. A fill never writes below the boundary.
- R5: A pinned load (op 2) writes the entry at index `lock_base` and raises `lock_base` by one. When `lock_base` is already NUM_ENTRIES-1, it asserts `cmd_err`, writes nothing and keeps `lock_base`.
- R6: A boundary write (op 5) takes `cmd_base` when it is at most NUM_ENTRIES-1. A larger value asserts `cmd_err` and leaves `lock_base` unchanged.
- R7: A global flush (op 3) clears the valid flag of every entry with index at or above `lock_base` and leaves the entries below it intact.
- R8: A flush by address (op 4) clears every valid entry that matches `cmd_vaddr` under its own page size, protected entries included.
- R9: Lowering `lock_base` unprotects every entry from the new value upward at once. A later global flush or fill can then remove or replace them.
- R10: A lookup reflects the entries as they were before the clock edge. A command's writes show in lookups only after the rising edge that samples it. `cmd_err` is combinational and is 0 for op 0 (no operation), ops 1, 3 and 4, and codes 6 and 7 (no operation).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | A valid entry matches `lk_vaddr` |
| lk_paddr | output | 32 | Translated physical address, 0 on miss |
| lk_index | output | $clog2(NUM_ENTRIES) | Index of the winning entry |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 fill, 2 pinned load, 3 global flush, 4 flush by address, 5 set boundary |
| cmd_vaddr | input | 32 | Virtual address for fill, pinned load and flush by address |
| cmd_paddr | input | 32 | Physical address for fill and pinned load |
| cmd_size | input | 2 | Page-size code for fill and pinned load |
| cmd_base | input | $clog2(NUM_ENTRIES)+1 | New boundary value for op 5 |
| cmd_err | output | 1 | Command rejected (full pinned region or boundary out of range) |
| lock_base | output | $clog2(NUM_ENTRIES) | Current lock boundary |

## Verification
The assertions take for granted that at most one command is presented per cycle and that `cmd_op`, `cmd_size` and `cmd_base` are driven with known values whenever `cmd_valid` is high. The random stimulus drives all command fields every cycle from a seeded generator, so this always holds. It draws virtual addresses from a small pool of upper-bit patterns so that entries of different page sizes overlap often and the multi-hit priority is exercised. It also draws boundary values a little beyond the legal range, so rejected writes occur next to accepted ones.

// File: rtl/lock_tlb_pkg.sv
package lock_tlb_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_FILL     = 3'd1,
        OP_PIN      = 3'd2,
        OP_FLUSH    = 3'd3,
        OP_FLUSH_VA = 3'd4,
        OP_SET_BASE = 3'd5
    } tlb_op_e;

    // page size codes
    localparam logic [1:0] SZ_1M  = 2'd0;
    localparam logic [1:0] SZ_64K = 2'd1;
    localparam logic [1:0] SZ_4K  = 2'd2;
    localparam logic [1:0] SZ_16M = 2'd3;

    typedef struct packed {
        logic        vld;
        logic [1:0]  size;
        logic [31:0] tag;
        logic [31:0] pbase;
    } tlb_entry_t;

    // bits kept for comparison (above the page offset)
    function automatic logic [31:0] page_mask(input logic [1:0] sz);
        logic [31:0] m;
        case (sz)
            SZ_4K:   m = 32'hFFFF_F000;
            SZ_64K:  m = 32'hFFFF_0000;
            SZ_1M:   m = 32'hFFF0_0000;
            default: m = 32'hFF00_0000;
        endcase
        return m;
    endfunction

    function automatic tlb_entry_t make_entry(input logic [31:0] va,
                                              input logic [31:0] pa,
                                              input logic [1:0]  sz);
        tlb_entry_t e;
        e.vld   = 1'b1;
        e.size  = sz;
        e.tag   = va & page_mask(sz);
        e.pbase = pa & page_mask(sz);
        return e;
    endfunction

endpackage

// File: rtl/lock_tlb_match.sv
module lock_tlb_match
    import lock_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] ents,
    input  logic [31:0]                  vaddr,
    output logic [NUM_ENTRIES-1:0]       hit_vec
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic [31:0] masked_va;
        assign masked_va  = vaddr & page_mask(ents[g].size);
        assign hit_vec[g] = ents[g].vld && (masked_va == ents[g].tag);
    end
endmodule

// File: rtl/lock_tlb_pick.sv
module lock_tlb_pick #(
    parameter int NUM_ENTRIES = 32,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hit_vec,
    output logic                   any_hit,
    output logic [IW-1:0]          win_idx
);
    // scan from the top so the lowest matching index is written last
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lock_tlb_victim.sv
module lock_tlb_victim #(
    parameter int NUM_ENTRIES = 32,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic [IW-1:0] base,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] victim,
    output logic [IW-1:0] rr_next
);
    localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

    always_comb begin
        victim  = (rr_ptr < base) ? base : rr_ptr;
        rr_next = (victim == LAST) ? base : victim + 1'b1;
    end
endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
    import lock_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [31:0]                        lk_vaddr,
    output logic                               lk_hit,
    output logic [31:0]                        lk_paddr,
    output logic [$clog2(NUM_ENTRIES)-1:0]     lk_index,
    input  logic                               cmd_valid,
    input  logic [2:0]                         cmd_op,
    input  logic [31:0]                        cmd_vaddr,
    input  logic [31:0]                        cmd_paddr,
    input  logic [1:0]                         cmd_size,
    input  logic [$clog2(NUM_ENTRIES):0]       cmd_base,
    output logic                               cmd_err,
    output logic [$clog2(NUM_ENTRIES)-1:0]     lock_base
);
    localparam int IW = $clog2(NUM_ENTRIES);
    localparam logic [IW-1:0] MAX_BASE = IW'(NUM_ENTRIES - 1);

    typedef struct packed {
        tlb_entry_t [NUM_ENTRIES-1:0] ent;
        logic [IW-1:0]                base;
        logic [IW-1:0]                rr;
    } tlb_state_t;

    tlb_state_t st_q, st_d;

    logic [NUM_ENTRIES-1:0] lk_hits_d, va_hits_d, vld_vec;
    logic                   any_hit_d;
    logic [IW-1:0]          win_idx_d, victim_d, rr_next_d;
    tlb_entry_t             win_ent_d;

    lock_tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_match (
        .ents(st_q.ent), .vaddr(lk_vaddr), .hit_vec(lk_hits_d)
    );

    lock_tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_fl_match (
        .ents(st_q.ent), .vaddr(cmd_vaddr), .hit_vec(va_hits_d)
    );

    lock_tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .hit_vec(lk_hits_d), .any_hit(any_hit_d), .win_idx(win_idx_d)
    );

    lock_tlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
        .base(st_q.base), .rr_ptr(st_q.rr), .victim(victim_d), .rr_next(rr_next_d)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
        assign vld_vec[g] = st_q.ent[g].vld;
    end

    // lookup result
    always_comb begin
        win_ent_d = st_q.ent[win_idx_d];
        lk_hit    = any_hit_d;
        lk_index  = win_idx_d;
        lk_paddr  = any_hit_d
                  ? (win_ent_d.pbase | (lk_vaddr & ~page_mask(win_ent_d.size)))
                  : 32'h0;
    end

    // next state
    always_comb begin
        st_d    = st_q;
        cmd_err = 1'b0;
        if (cmd_valid) begin
            case (tlb_op_e'(cmd_op))
                OP_FILL: begin
                    st_d.ent[victim_d] = make_entry(cmd_vaddr, cmd_paddr, cmd_size);
                    st_d.rr            = rr_next_d;
                end
                OP_PIN: begin
                    if (st_q.base == MAX_BASE) begin
                        cmd_err = 1'b1;
                    end else begin
                        st_d.ent[st_q.base] = make_entry(cmd_vaddr, cmd_paddr, cmd_size);
                        st_d.base           = st_q.base + 1'b1;
                    end
                end
                OP_FLUSH: begin
                    for (int i = 0; i < NUM_ENTRIES; i++) begin
                        if (IW'(i) >= st_q.base) st_d.ent[i].vld = 1'b0;
                    end
                end
                OP_FLUSH_VA: begin
                    for (int i = 0; i < NUM_ENTRIES; i++) begin
                        if (va_hits_d[i]) st_d.ent[i].vld = 1'b0;
                    end
                end
                OP_SET_BASE: begin
                    if (cmd_base > (IW+1)'(NUM_ENTRIES - 1)) cmd_err = 1'b1;
                    else                                    st_d.base = cmd_base[IW-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_base = st_q.base;

endmodule

// File: rtl/lock_tlb_chk.sv
module lock_tlb_chk #(
    parameter int NUM_ENTRIES = 32,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [2:0]             cmd_op,
    input logic [IW:0]            cmd_base,
    input logic                   cmd_err,
    input logic [IW-1:0]          lock_base,
    input logic                   lk_hit,
    input logic [IW-1:0]          lk_index,
    input logic [NUM_ENTRIES-1:0] vld_vec
);
    function automatic logic [NUM_ENTRIES-1:0] upper_mask(input logic [IW-1:0] b);
        logic [NUM_ENTRIES-1:0] m;
        for (int i = 0; i < NUM_ENTRIES; i++) m[i] = (IW'(i) >= b);
        return m;
    endfunction

    logic pin_c, flush_c, setb_c, setb_bad;
    assign pin_c    = cmd_valid && (cmd_op == 3'd2);
    assign flush_c  = cmd_valid && (cmd_op == 3'd3);
    assign setb_c   = cmd_valid && (cmd_op == 3'd5);
    assign setb_bad = cmd_base > (IW+1)'(NUM_ENTRIES - 1);

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_vec == '0) |-> !lk_hit);                                          // R1
    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> vld_vec[lk_index]);                                         // R3
    AST_PIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_c && !cmd_err) |=> (lock_base == $past(lock_base) + 1'b1));       // R5
    AST_PIN_WRITES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_c && !cmd_err) |=> vld_vec[$past(lock_base)]);                    // R5
    AST_PIN_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_c && cmd_err) |=> (lock_base == $past(lock_base)));               // R5
    AST_BASE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (setb_c && setb_bad) |=> (lock_base == $past(lock_base)));             // R6
    AST_BASE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (setb_c && !setb_bad) |=> (lock_base == $past(cmd_base[IW-1:0])));     // R6
    AST_FLUSH_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        flush_c |=> ((vld_vec & upper_mask(lock_base)) == '0));                // R7
    AST_FLUSH_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_c |=> (((vld_vec ^ $past(vld_vec)) & ~upper_mask(lock_base)) == '0)); // R7
endmodule

bind lock_tlb lock_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_base(cmd_base), .cmd_err(cmd_err), .lock_base(lock_base),
    .lk_hit(lk_hit), .lk_index(lk_index), .vld_vec(vld_vec)
);

// File: tb/lock_tlb_bench.sv
`timescale 1ns/1ps
module lock_tlb_bench;
    localparam int N  = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   lk_vaddr;
    logic          lk_hit;
    logic [31:0]   lk_paddr;
    logic [IW-1:0] lk_index;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [31:0]   cmd_vaddr, cmd_paddr;
    logic [1:0]    cmd_size;
    logic [IW:0]   cmd_base;
    logic          cmd_err;
    logic [IW-1:0] lock_base;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lock_tlb #(.NUM_ENTRIES(N)) u_lock_tlb (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .lk_index(lk_index), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_vaddr(cmd_vaddr), .cmd_paddr(cmd_paddr),
        .cmd_size(cmd_size), .cmd_base(cmd_base), .cmd_err(cmd_err),
        .lock_base(lock_base)
    );

    // reference model
    bit          m_vld [N];
    logic [31:0] m_tag [N];
    logic [31:0] m_pb  [N];
    logic [1:0]  m_sz  [N];
    int          m_base, m_rr;

    function automatic logic [31:0] m_mask(input logic [1:0] sz);
        case (sz)
            2'd2:    return 32'hFFFF_F000;
            2'd1:    return 32'hFFFF_0000;
            2'd0:    return 32'hFFF0_0000;
            default: return 32'hFF00_0000;
        endcase
    endfunction

    function automatic bit m_match(input int i, input logic [31:0] va);
        return m_vld[i] && ((va & m_mask(m_sz[i])) == m_tag[i]);
    endfunction

    task automatic m_write(input int i, input logic [31:0] va, input logic [31:0] pa,
                           input logic [1:0] sz);
        m_vld[i] = 1'b1;
        m_sz[i]  = sz;
        m_tag[i] = va & m_mask(sz);
        m_pb[i]  = pa & m_mask(sz);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input string req);
        int          idx = -1;
        logic [31:0] pa  = 32'h0;
        lk_vaddr = va;
        #1;
        for (int i = N - 1; i >= 0; i--) if (m_match(i, va)) idx = i;
        if (idx >= 0) pa = m_pb[idx] | (va & ~m_mask(m_sz[idx]));
        check(lk_hit == (idx >= 0), req, "hit", 32'(lk_hit), 32'(idx >= 0));
        check(lk_paddr == pa, req, "paddr", lk_paddr, pa);
        if (idx >= 0) check(int'(lk_index) == idx, req, "index", 32'(lk_index), 32'(idx));
    endtask

    task automatic cmd(input int op, input logic [31:0] va, input logic [31:0] pa,
                       input logic [1:0] sz, input int b, input string req);
        bit exp_err;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_vaddr = va;
        cmd_paddr = pa;
        cmd_size  = sz;
        cmd_base  = (IW+1)'(b);
        #1;
        exp_err = (op == 2 && m_base == N - 1) || (op == 5 && b > N - 1);
        check(cmd_err == exp_err, req, "cmd_err", 32'(cmd_err), 32'(exp_err));
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        case (op)
            1: begin
                int v = (m_rr < m_base) ? m_base : m_rr;
                m_write(v, va, pa, sz);
                m_rr = (v == N - 1) ? m_base : v + 1;
            end
            2: if (!exp_err) begin m_write(m_base, va, pa, sz); m_base++; end
            3: for (int i = 0; i < N; i++) if (i >= m_base) m_vld[i] = 1'b0;
            4: begin
                bit hits [N];
                for (int i = 0; i < N; i++) hits[i] = m_match(i, va);
                for (int i = 0; i < N; i++) if (hits[i]) m_vld[i] = 1'b0;
            end
            5: if (!exp_err) m_base = b;
            default: ;
        endcase
        check(int'(lock_base) == m_base, req, "lock_base", 32'(lock_base), 32'(m_base));
    endtask

    function automatic logic [31:0] pool_va();
        logic [31:0] v = $urandom;
        v[31:24] = 8'hA0 + 8'($urandom % 2);
        v[23:20] = 4'($urandom % 2);
        v[19:16] = 4'($urandom % 2);
        v[15:12] = 4'($urandom % 2);
        return v;
    endfunction

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_base = 0; m_rr = 0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_vaddr = '0;
        cmd_paddr = '0; cmd_size = '0; cmd_base = '0; lk_vaddr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(lock_base == '0, "R1", "reset lock_base", 32'(lock_base), 32'h0);
        look(32'h1234_5ABC, "R1");

        // R10: pinned load not visible before the edge
        @(negedge clk);
        lk_vaddr = 32'h1234_5ABC; cmd_valid = 1'b1; cmd_op = 3'd2;
        cmd_vaddr = 32'h1234_5000; cmd_paddr = 32'h8765_4000; cmd_size = 2'd2;
        #1 check(!lk_hit, "R10", "pre-edge hit", 32'(lk_hit), 32'h0);
        @(posedge clk); #1 cmd_valid = 1'b0;
        m_write(0, 32'h1234_5000, 32'h8765_4000, 2'd2); m_base = 1;
        look(32'h1234_5ABC, "R10");
        look(32'h1234_6ABC, "R2");
        cmd(2, 32'h2222_0000, 32'h5555_0000, 2'd1, 0, "R5");
        look(32'h2222_F123, "R2");
        cmd(2, 32'h3330_0000, 32'h4440_0000, 2'd0, 0, "R5");
        look(32'h333A_BCDE, "R2");
        look(32'h334A_BCDE, "R2");
        cmd(2, 32'h7700_0000, 32'h0100_0000, 2'd3, 0, "R5");
        look(32'h77FE_DCBA, "R2");
        // R3: overlapping fill lands at index 4; index 0 still wins
        cmd(1, 32'h1234_0000, 32'h9999_0000, 2'd1, 0, "R4");
        look(32'h1234_5ABC, "R3");
        look(32'h1234_7ABC, "R3");
        cmd(3, 0, 0, 0, 0, "R7");
        look(32'h1234_7ABC, "R7");
        look(32'h2222_0010, "R7");
        cmd(4, 32'h1234_5FFF, 0, 0, 0, "R8");
        look(32'h1234_5ABC, "R8");
        cmd(5, 0, 0, 0, 2, "R9");
        cmd(3, 0, 0, 0, 0, "R9");
        look(32'h77FE_DCBA, "R9");
        look(32'h2222_F123, "R9");
        cmd(5, 0, 0, 0, 40, "R6");
        cmd(5, 0, 0, 0, 32, "R6");
        cmd(5, 0, 0, 0, 30, "R6");
        cmd(2, 32'h5000_0000, 32'h6000_0000, 2'd2, 0, "R5");
        cmd(2, 32'h5100_0000, 32'h6100_0000, 2'd2, 0, "R5");
        look(32'h5100_0123, "R5");
        cmd(5, 0, 0, 0, 3, "R6");
        for (int k = 0; k < 40; k++) begin
            cmd(1, 32'hC000_0000 + 32'(k) * 32'h1000, 32'h0000_0000 + 32'(k) * 32'h1000,
                2'd2, 0, "R4");
            look(32'hC000_0000 + 32'(k) * 32'h1000 + 32'h44, "R4");
        end
        cmd(7, 32'h2222_0000, 0, 0, 0, "R10");
        look(32'h2222_F123, "R10");

        for (int k = 0; k < 600; k++) begin
            int r = $urandom % 20;
            int op = (r < 8) ? 1 : (r < 11) ? 2 : (r < 12) ? 3 : (r < 15) ? 4 :
                     (r < 18) ? 5 : 0;
            cmd(op, pool_va(), $urandom, 2'($urandom), $urandom % 40,
                (op == 1) ? "R4" : (op == 2) ? "R5" : (op == 3) ? "R7" :
                (op == 4) ? "R8" : (op == 5) ? "R6" : "R10");
            look(pool_va(), "R3");
            look(pool_va(), "R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule